// File: doc/BRIEF.md
# Banked Split-Port SRAM Access Sequencer

This block sequences single accesses to a memory of eight banks, each 256 rows by 128 columns, built from cells with a separate single-ended read port. An 11-bit word address selects a bank (upper three bits) and a row (lower eight bits). For the addressed bank only, the block drives read-port precharge, the read wordline, the write wordline and the float control of the selected row's virtual cell supply. The row index is presented on its own output. The cell storage is a behavioural model inside the block.

A write collapses the cell supply while the write wordline is high. It then restores the supply before the wordline drops, so a stored one is pulled back to the full rail. A read precharges the read bitline, raises the read wordline and captures the word into a register. One spare row and one spare column can be configured while the block is idle. A matching row is served from a spare strip, and the spare column carries a copy of a chosen data bit.

Top module: `bank_sram_seq`

## Requirements
- R1: Address bits [10:8] pick the bank and bits [7:0] the row. The strip vectors `pre_bk`, `rwl_bk`, `wwl_bk` and `vdd_on_bk` hold one bit per bank at index equal to the bank number. Bit 8 is the spare-row strip. `wl_row` shows the decoded row.
- R2: A write accepted at a clock edge runs four phases over the next four cycles. First the bitlines are driven with the wordline low. Then the wordline is high with the supply floated. Then the wordline stays high with the supply back on. Finally the wordline is low. The block then returns to idle.
- R3: `vdd_on_bk` is low only for the strip whose write wordline is high. The supply is back on for a full cycle before that wordline falls.
- R4: A read runs three phases: precharge of the addressed strip, then the read wordline of that strip, then capture. No write wordline is high during a read.
- R5: Only the addressed strip ever sees precharge, a read wordline, a write wordline or a floated supply.
- R6: At most one wordline of either kind is high across all strips in any cycle.
- R7: `busy` is high from the cycle after acceptance until the last phase ends. A command presented while busy is dropped and never executed.
- R8: `rd_valid` is high for exactly one cycle, in the capture phase. `rd_data` then equals the last data written to that address, including a write made just before.
- R9: When the spare row is enabled and the address equals its configured address, the access uses strip 8 with `wl_row` = 0. The main row keeps its contents, and it is reachable again once the spare row is disabled.
- R10: With the spare column enabled at index c, `wbl[128]` equals write data bit c during the write phases. Without it, `wbl[128]` is 0. `wbl[127:0]` carries the write data. Data read back through the spare column is unchanged.
- R11: A configuration load (`cfg_load`) takes effect only when the block is idle. A load while busy is ignored.
- R12: After reset, `busy`, `rd_valid` and all precharge and wordline strips are 0, and `vdd_on_bk` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 11 | Word address |
| cmd_wdata | input | 128 | Write data |
| cfg_load | input | 1 | Load the spare configuration |
| cfg_row_en | input | 1 | Enable the spare row |
| cfg_row_addr | input | 11 | Address steered to the spare row |
| cfg_col_en | input | 1 | Enable the spare column |
| cfg_col_idx | input | 7 | Column steered to the spare |
| busy | output | 1 | Access in progress |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | 128 | Read data |
| pre_bk | output | 9 | Read-bitline precharge per strip |
| rwl_bk | output | 9 | Read wordline per strip |
| wwl_bk | output | 9 | Write wordline per strip |
| vdd_on_bk | output | 9 | Selected-row supply on per strip (0 = floating) |
| wl_row | output | 8 | Row index within the strip |
| wbl | output | 129 | Write bitline data, bit 128 = spare column |

## Verification
Writes and reads use all-ones and all-zeros words at the two address extremes, so a wrong bank decode or a stuck bit shows as a mismatch. Alternating and inverted words at one address show that a rewrite replaces the old data and that a read directly after a write sees the new word. A command slipped into the middle of a write tells a dropped command apart from one that is queued. The same address is used before, during and after spare-row enabling, so steering is told apart from overwriting. Spare-column writes with the chosen bit set and then cleared show that the copy follows the data and is not fixed.

// File: rtl/bsq_pkg.sv
// Shared types for the banked split-port SRAM sequencer.
package bsq_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_W_SETUP,
        PH_W_FLOAT,
        PH_W_RESTORE,
        PH_W_RELEASE,
        PH_R_PRE,
        PH_R_ACCESS,
        PH_R_CAPTURE
    } phase_e;
endpackage

// File: rtl/bsq_phase_fsm.sv
// Phase sequencer: steps one access through its fixed phase list.
// Assumes start is only raised while the phase is idle.
module bsq_phase_fsm
    import bsq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   start_write,
    output phase_e phase
);
    phase_e nxt;

    // next-phase selection
    always_comb begin
        nxt = phase;
        case (phase)
            PH_IDLE:      if (start) nxt = start_write ? PH_W_SETUP : PH_R_PRE;
            PH_W_SETUP:   nxt = PH_W_FLOAT;
            PH_W_FLOAT:   nxt = PH_W_RESTORE;
            PH_W_RESTORE: nxt = PH_W_RELEASE;
            PH_W_RELEASE: nxt = PH_IDLE;
            PH_R_PRE:     nxt = PH_R_ACCESS;
            PH_R_ACCESS:  nxt = PH_R_CAPTURE;
            PH_R_CAPTURE: nxt = PH_IDLE;
            default:      nxt = PH_IDLE;
        endcase
    end

    // phase register
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_IDLE;
        else        phase <= nxt;
    end
endmodule

// File: rtl/bsq_decode.sv
// Address decoder: splits a word address into a one-hot strip select
// (banks plus one spare-row strip at the top index) and a row index.
// Assumes the spare row configuration is stable during an access.
module bsq_decode #(
    parameter int NUM_BANKS = 8,
    parameter int ROWS      = 256,
    localparam int RW       = $clog2(ROWS),
    localparam int BW       = $clog2(NUM_BANKS),
    localparam int AW       = RW + BW
) (
    input  logic [AW-1:0]      addr,
    input  logic               fix_en,
    input  logic [AW-1:0]      fix_addr,
    output logic               spare_hit,
    output logic [NUM_BANKS:0] strip,
    output logic [RW-1:0]      row
);
    // spare-row match
    assign spare_hit = fix_en && (addr == fix_addr);
    assign strip[NUM_BANKS] = spare_hit;
    // row within strip (spare strip holds a single row)
    assign row = spare_hit ? '0 : addr[RW-1:0];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        // bank select for one bank
        assign strip[b] = !spare_hit && (addr[AW-1:RW] == BW'(b));
    end
endmodule

// File: rtl/bsq_array.sv
// Behavioural cell storage: main words, one spare row, one spare column.
// The spare column bit records the data bit at the configured index;
// reads substitute it when the column repair is enabled.
module bsq_array #(
    parameter int WORDS = 2048,
    parameter int COLS  = 128,
    localparam int AW   = $clog2(WORDS),
    localparam int CW   = $clog2(COLS)
) (
    input  logic            clk,
    input  logic            we,
    input  logic            spare_hit,
    input  logic [AW-1:0]   idx,
    input  logic [COLS-1:0] wdata,
    input  logic            col_en,
    input  logic [CW-1:0]   col_idx,
    output logic [COLS-1:0] rdata
);
    logic [COLS-1:0] main_q [WORDS];
    logic [WORDS-1:0] scol_q;
    logic [COLS:0]   srow_q;
    logic [COLS-1:0] raw;
    logic            sbit;

    // cell write on the restore phase
    always_ff @(posedge clk) begin
        if (we) begin
            if (spare_hit) begin
                srow_q <= {wdata[col_idx], wdata};
            end else begin
                main_q[idx] <= wdata;
                scol_q[idx] <= wdata[col_idx];
            end
        end
    end

    // read path with column substitution
    always_comb begin
        raw   = spare_hit ? srow_q[COLS-1:0] : main_q[idx];
        sbit  = spare_hit ? srow_q[COLS] : scol_q[idx];
        rdata = raw;
        if (col_en) rdata[col_idx] = sbit;
    end
endmodule

// File: rtl/bank_sram_seq.sv
// Top: accepts one access at a time, latches it, decodes it and drives the
// per-strip precharge, wordline and supply-float controls phase by phase.
// Assumes the controls are consumed by cells at the strip/row they name.
module bank_sram_seq
    import bsq_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int ROWS      = 256,
    parameter int COLS      = 128,
    localparam int RW       = $clog2(ROWS),
    localparam int AW       = RW + $clog2(NUM_BANKS),
    localparam int CW       = $clog2(COLS),
    localparam int NS       = NUM_BANKS + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic            cmd_write,
    input  logic [AW-1:0]   cmd_addr,
    input  logic [COLS-1:0] cmd_wdata,
    input  logic            cfg_load,
    input  logic            cfg_row_en,
    input  logic [AW-1:0]   cfg_row_addr,
    input  logic            cfg_col_en,
    input  logic [CW-1:0]   cfg_col_idx,
    output logic            busy,
    output logic            rd_valid,
    output logic [COLS-1:0] rd_data,
    output logic [NS-1:0]   pre_bk,
    output logic [NS-1:0]   rwl_bk,
    output logic [NS-1:0]   wwl_bk,
    output logic [NS-1:0]   vdd_on_bk,
    output logic [RW-1:0]   wl_row,
    output logic [COLS:0]   wbl
);
    phase_e          phase;
    logic            idle, start, spare_hit, wr_phase;
    logic [NS-1:0]   strip;
    logic [AW-1:0]   addr_q, fix_addr_q;
    logic [COLS-1:0] wdata_q, arr_rdata;
    logic            write_q, fix_en_q, col_en_q;
    logic [CW-1:0]   col_idx_q;

    assign idle  = (phase == PH_IDLE);
    assign start = idle && cmd_valid;
    assign busy  = !idle;

    // command latch at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            write_q <= 1'b0;
        end else if (start) begin
            addr_q  <= cmd_addr;
            wdata_q <= cmd_wdata;
            write_q <= cmd_write;
        end
    end

    // repair configuration, loadable only while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fix_en_q   <= 1'b0;
            fix_addr_q <= '0;
            col_en_q   <= 1'b0;
            col_idx_q  <= '0;
        end else if (cfg_load && idle) begin
            fix_en_q   <= cfg_row_en;
            fix_addr_q <= cfg_row_addr;
            col_en_q   <= cfg_col_en;
            col_idx_q  <= cfg_col_idx;
        end
    end

    bsq_phase_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start),
        .start_write(cmd_write), .phase(phase)
    );

    bsq_decode #(.NUM_BANKS(NUM_BANKS), .ROWS(ROWS)) u_dec (
        .addr(addr_q), .fix_en(fix_en_q), .fix_addr(fix_addr_q),
        .spare_hit(spare_hit), .strip(strip), .row(wl_row)
    );

    bsq_array #(.WORDS(NUM_BANKS * ROWS), .COLS(COLS)) u_arr (
        .clk(clk), .we(phase == PH_W_RESTORE), .spare_hit(spare_hit),
        .idx(addr_q), .wdata(wdata_q), .col_en(col_en_q),
        .col_idx(col_idx_q), .rdata(arr_rdata)
    );

    assign wr_phase = (phase == PH_W_SETUP) || (phase == PH_W_FLOAT) ||
                      (phase == PH_W_RESTORE) || (phase == PH_W_RELEASE);

    // strip controls per phase
    always_comb begin
        pre_bk    = (phase == PH_R_PRE) ? strip : '0;
        rwl_bk    = (phase == PH_R_ACCESS) ? strip : '0;
        wwl_bk    = ((phase == PH_W_FLOAT) || (phase == PH_W_RESTORE)) ? strip : '0;
        vdd_on_bk = (phase == PH_W_FLOAT) ? ~strip : '1;
        wbl       = wr_phase ? {col_en_q & wdata_q[col_idx_q], wdata_q} : '0;
    end

    // read capture register and strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= (phase == PH_R_ACCESS);
            if (phase == PH_R_ACCESS) rd_data <= arr_rdata;
        end
    end
endmodule

// File: rtl/bsq_checks.sv
// Protocol checker for bank_sram_seq: wordline exclusivity, supply
// float/restore ordering, precharge ordering and read strobe shape.
module bsq_checks #(
    parameter int NS = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          rd_valid,
    input logic [NS-1:0] pre_bk,
    input logic [NS-1:0] rwl_bk,
    input logic [NS-1:0] wwl_bk,
    input logic [NS-1:0] vdd_on_bk
);
    a_r6_one_wordline: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rwl_bk, wwl_bk}));
    a_r3_float_under_wordline: assert property (@(posedge clk) disable iff (!rst_n)
        (~vdd_on_bk != '0) |-> (wwl_bk == ~vdd_on_bk));
    a_r3_restore_before_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (~vdd_on_bk != '0) |=> ((&vdd_on_bk) && (wwl_bk == $past(wwl_bk))));
    a_r3_fall_after_restore: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(|wwl_bk) |-> $past(&vdd_on_bk));
    a_r4_precharge_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|rwl_bk) |-> ($past(pre_bk) == rwl_bk));
    a_r4_no_write_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        (|{pre_bk, rwl_bk}) |-> (wwl_bk == '0));
    a_r7_busy_when_active: assert property (@(posedge clk) disable iff (!rst_n)
        (|{pre_bk, rwl_bk, wwl_bk}) |-> busy);
    a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
    a_r8_valid_after_access: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(|rwl_bk));
endmodule

bind bank_sram_seq bsq_checks #(.NS(NS)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .rd_valid(rd_valid),
    .pre_bk(pre_bk), .rwl_bk(rwl_bk), .wwl_bk(wwl_bk), .vdd_on_bk(vdd_on_bk)
);

// File: tb/bank_sram_seq_bench.sv
// Scoreboard bench: access tasks check phase controls and queue expected
// read words; a monitor pops and compares them on each read strobe.
module bank_sram_seq_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0, cmd_write = 1'b0;
    logic [10:0]  cmd_addr = '0;
    logic [127:0] cmd_wdata = '0;
    logic         cfg_load = 1'b0, cfg_row_en = 1'b0, cfg_col_en = 1'b0;
    logic [10:0]  cfg_row_addr = '0;
    logic [6:0]   cfg_col_idx = '0;
    logic         busy, rd_valid;
    logic [127:0] rd_data;
    logic [8:0]   pre_bk, rwl_bk, wwl_bk, vdd_on_bk;
    logic [7:0]   wl_row;
    logic [128:0] wbl;

    int checks = 0;
    int failures = 0;
    logic [127:0] exp_q [$];

    always #2.5 clk = ~clk;

    bank_sram_seq u_bank_sram_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cfg_load(cfg_load),
        .cfg_row_en(cfg_row_en), .cfg_row_addr(cfg_row_addr),
        .cfg_col_en(cfg_col_en), .cfg_col_idx(cfg_col_idx), .busy(busy),
        .rd_valid(rd_valid), .rd_data(rd_data), .pre_bk(pre_bk),
        .rwl_bk(rwl_bk), .wwl_bk(wwl_bk), .vdd_on_bk(vdd_on_bk),
        .wl_row(wl_row), .wbl(wbl)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [159:0] act, input logic [159:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] strip_of(input logic [10:0] a, input bit sp);
        return sp ? 9'h100 : (9'h1 << a[10:8]);
    endfunction

    task automatic drive_cmd(input bit w, input logic [10:0] a, input logic [127:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_write = w; cmd_addr = a; cmd_wdata = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic do_write(input logic [10:0] a, input logic [127:0] d,
                            input bit sp, input logic sbit);
        logic [8:0] s;
        s = strip_of(a, sp);
        drive_cmd(1'b1, a, d);
        chk(busy && wwl_bk == 0, "R2 setup wordline low", {busy, wwl_bk}, {1'b1, 9'h0});
        chk(wbl == {sbit, d}, "R10 write bitlines", wbl, {sbit, d});
        @(negedge clk);
        chk(wwl_bk == s, "R1 R5 write strip", wwl_bk, s);
        chk(vdd_on_bk == ~s, "R3 supply floated", vdd_on_bk, ~s);
        chk(wl_row == (sp ? 8'h0 : a[7:0]), "R1 R9 row index", wl_row, sp ? 8'h0 : a[7:0]);
        @(negedge clk);
        chk(wwl_bk == s && vdd_on_bk == 9'h1FF, "R3 restore with wordline high",
            {wwl_bk, vdd_on_bk}, {s, 9'h1FF});
        @(negedge clk);
        chk(wwl_bk == 0 && busy, "R2 release", {busy, wwl_bk}, {1'b1, 9'h0});
        @(negedge clk);
        chk(!busy, "R7 idle after write", busy, 1'b0);
    endtask

    task automatic do_read(input logic [10:0] a, input logic [127:0] d, input bit sp);
        logic [8:0] s;
        s = strip_of(a, sp);
        exp_q.push_back(d);
        drive_cmd(1'b0, a, d);
        chk(pre_bk == s && rwl_bk == 0, "R4 R5 precharge", {pre_bk, rwl_bk}, {s, 9'h0});
        @(negedge clk);
        chk(rwl_bk == s && pre_bk == 0 && wwl_bk == 0, "R4 read wordline",
            {rwl_bk, pre_bk, wwl_bk}, {s, 18'h0});
        @(negedge clk);
        @(negedge clk);
        chk(!busy && !rd_valid, "R8 strobe single cycle", {busy, rd_valid}, 2'b00);
    endtask

    task automatic load_cfg(input bit ren, input logic [10:0] ra,
                            input bit cen, input logic [6:0] ci);
        @(negedge clk);
        cfg_load = 1'b1; cfg_row_en = ren; cfg_row_addr = ra;
        cfg_col_en = cen; cfg_col_idx = ci;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    // scoreboard monitor and wordline exclusivity
    always @(negedge clk) begin
        if (rst_n) begin
            if ($countones({rwl_bk, wwl_bk}) > 1)
                chk(1'b0, "R6 one wordline", {rwl_bk, wwl_bk}, 18'h0);
            if (rd_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 R8 unexpected read strobe", rd_data, 128'h0);
                end else begin
                    logic [127:0] e;
                    e = exp_q.pop_front();
                    chk(rd_data == e, "R8 read data", rd_data, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [127:0] alt, d1, d2;
        alt = {4{32'hA5A5_5A5A}};
        d1  = {4{32'h1357_9BDF}};
        d2  = {4{32'hFEDC_0123}};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !rd_valid && pre_bk == 0 && rwl_bk == 0 && wwl_bk == 0 &&
            vdd_on_bk == 9'h1FF, "R12 reset state",
            {busy, rd_valid, pre_bk, rwl_bk, wwl_bk, vdd_on_bk},
            {2'b00, 27'h0, 9'h1FF});

        // extremes and patterns
        do_write(11'h000, '1, 1'b0, 1'b0);
        do_read(11'h000, '1, 1'b0);
        do_write(11'h7FF, '0, 1'b0, 1'b0);
        do_read(11'h7FF, '0, 1'b0);
        do_read(11'h000, '1, 1'b0);
        do_write(11'h2A5, alt, 1'b0, 1'b0);
        do_read(11'h2A5, alt, 1'b0);
        do_write(11'h2A5, ~alt, 1'b0, 1'b0);
        do_read(11'h2A5, ~alt, 1'b0);

        // R7: a command during a write is dropped
        drive_cmd(1'b1, 11'h100, d1);
        cmd_valid = 1'b1; cmd_write = 1'b0; cmd_addr = 11'h101;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(!busy, "R7 idle after dropped command", busy, 1'b0);
        @(negedge clk);
        chk(!busy && pre_bk == 0, "R7 dropped command not run", {busy, pre_bk}, 10'h0);
        do_read(11'h100, d1, 1'b0);

        // R11: configuration ignored while busy
        drive_cmd(1'b0, 11'h100, d1);
        exp_q.push_back(d1);
        cfg_load = 1'b1; cfg_row_en = 1'b1; cfg_row_addr = 11'h055;
        @(negedge clk);
        cfg_load = 1'b0; cfg_row_en = 1'b0;
        repeat (2) @(negedge clk);
        do_write(11'h055, d2, 1'b0, 1'b0);   // R11 normal strip expected
        do_read(11'h055, d2, 1'b0);

        // R9: spare row steering
        do_write(11'h123, d1, 1'b0, 1'b0);
        load_cfg(1'b1, 11'h123, 1'b0, 7'd0);
        do_write(11'h123, d2, 1'b1, 1'b0);
        do_read(11'h123, d2, 1'b1);
        load_cfg(1'b0, 11'h123, 1'b0, 7'd0);
        do_read(11'h123, d1, 1'b0);

        // R10: spare column copy
        load_cfg(1'b0, 11'h0, 1'b1, 7'd5);
        do_write(11'h040, 128'h20, 1'b0, 1'b1);
        do_read(11'h040, 128'h20, 1'b0);
        do_write(11'h041, ~128'h20, 1'b0, 1'b0);
        do_read(11'h041, ~128'h20, 1'b0);

        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "R8 all reads returned", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule